// File: doc/BRIEF.md
# Boot ROM Multiplexed Port Controller

This block connects an internal host request channel to a narrow external bus that serves a boot ROM or an external byte-wide register. The external bus has an 8-bit shared address/data path, two auxiliary lines and an active-low select. Every access moves exactly one byte and runs in three steps. Two address cycles place the 18-bit byte address onto the shared path so that two external latches can capture it. A data cycle follows, which either drives the write byte or releases the path and samples the read byte.

The access direction is sent to the external side as two active-low strobes. They travel inside the first latched address byte. The top two address bits travel on auxiliary line 0, one bit in each address cycle. This gives a 256KB space. The length of each cycle in clocks is taken from a plain control input at the moment a request is accepted.

Requests use a valid/ready handshake. The host holds `req_valid` and the request fields stable until a clock edge where `req_ready` is also high. `req_ready` is high only while the port is idle, so back-pressure lasts for a whole access. The response is a one-cycle `rsp_valid` pulse that cannot be stalled. The host must take `rsp_data` in that cycle.

Top module: `bootrom_port_ctrl`

## Requirements
- R1: Out of reset and whenever idle: `rom_sel_n`=1, `rom_ad_oe`=0, `rom_ad_o`=0, `rom_aux`=0, `busy`=0, `req_ready`=1, `rsp_valid`=0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle until the access ends, `req_ready` is 0 and `req_valid` is ignored.
- R3: An accepted access runs three phases, each L clocks long, in this order: address-low, address-high, data. L is `phase_len` sampled at acceptance, and a value of 0 is treated as 1. `rom_sel_n` is 0 and `busy` is 1 throughout all three phases.
- R4: In the address-low phase the path is driven (`rom_ad_oe`=1) with `rom_ad_o[7:2]`=addr[7:2], `rom_ad_o[1]`=write-enable-n (0 for a write), `rom_ad_o[0]`=output-enable-n (0 for a read), and `rom_aux[0]`=addr[16].
- R5: In the address-high phase the path is driven with `rom_ad_o`=addr[15:8] and `rom_aux[0]`=addr[17].
- R6: `rom_aux[1]` is the latch strobe. In each address phase it is 1 on that phase's final clock only.
- R7: In the data phase `rom_aux[1:0]`=addr[1:0]. For a write the path is driven with `req_wdata`. For a read `rom_ad_oe`=0 and `rom_ad_o`=0.
- R8: A read captures `rom_ad_i` on the last clock of the data phase. In the cycle after the data phase, `rsp_valid` is 1 for exactly one cycle, `busy` is 0, and `rsp_data` holds the captured byte.
- R9: A write completes with the same one-cycle `rsp_valid` pulse. `rsp_data` keeps the byte from the most recent read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Port idle, request will be taken |
| req_addr | input | 18 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| phase_len | input | LEN_W (4) | Clocks per phase (0 treated as 1) |
| busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Last byte read |
| rom_ad_o | output | 8 | Shared address/data path, outgoing value |
| rom_ad_oe | output | 1 | Drive enable for the shared path |
| rom_ad_i | input | 8 | Shared address/data path, incoming value |
| rom_aux | output | 2 | [1] latch strobe / addr[1], [0] addr[16]/addr[17]/addr[0] |
| rom_sel_n | output | 1 | Active-low device select |

## Verification
The embedded properties check the following on every cycle:
- the shared path and auxiliary lines are released whenever the select is high;
- a read data phase never drives the path;
- an accepted request always raises busy;
- the phase counter never passes the latched length;
- the completion pulse lasts one cycle and only follows a data phase.

The bench scenarios show the rest, by comparing every pin in every cycle of each access:
- the exact bit placement of address and strobes in each latched byte;
- the strobe position at the end of each address phase;
- phase lengths, including the zero-length case;
- capture of the read byte on the final data clock only, because the bench presents the wrong byte earlier in that phase;
- requests raised mid-access being ignored.

// File: rtl/brp_pkg.sv
package brp_pkg;
  localparam int ADDR_W = 18;
  localparam int BYTE_W = 8;
  typedef enum logic [1:0] {PH_IDLE, PH_ALO, PH_AHI, PH_DATA} phase_e;
endpackage

// File: rtl/brp_timer.sv
module brp_timer #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LEN_W-1:0] len_m1,
  output logic             last
);
  logic [LEN_W-1:0] cnt;

  assign last = run && (cnt == len_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || last)   cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R3: counter stays within the latched phase length
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= len_m1));
endmodule

// File: rtl/brp_pinmux.sv
module brp_pinmux
  import brp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              last,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ad_o,
  output logic              ad_oe,
  output logic [1:0]        aux,
  output logic              sel_n
);
  always_comb begin
    ad_o  = '0;
    ad_oe = 1'b0;
    aux   = 2'b00;
    sel_n = 1'b1;
    case (phase)
      PH_ALO: begin
        ad_o  = {addr[7:2], ~write, write};
        ad_oe = 1'b1;
        aux   = {last, addr[16]};
        sel_n = 1'b0;
      end
      PH_AHI: begin
        ad_o  = addr[15:8];
        ad_oe = 1'b1;
        aux   = {last, addr[17]};
        sel_n = 1'b0;
      end
      PH_DATA: begin
        ad_o  = write ? wdata : '0;
        ad_oe = write;
        aux   = addr[1:0];
        sel_n = 1'b0;
      end
      default: ;
    endcase
  end

  // R1: nothing driven while deselected
  a_r1_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> (!ad_oe && aux == 2'b00));
  // R7: read data phase leaves the path floating
  a_r7_read_float: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && !write) |-> !ad_oe);
endmodule

// File: rtl/brp_sequencer.sv
module brp_sequencer
  import brp_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic [LEN_W-1:0]  phase_len,
  input  logic [BYTE_W-1:0] rom_ad_i,
  input  logic              last,
  output phase_e            phase,
  output logic [LEN_W-1:0]  len_m1,
  output logic [ADDR_W-1:0] addr_q,
  output logic              write_q,
  output logic [BYTE_W-1:0] wdata_q,
  output logic              req_ready,
  output logic              busy,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data
);
  logic accept;

  assign req_ready = (phase == PH_IDLE);
  assign busy      = (phase != PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      len_m1    <= '0;
      addr_q    <= '0;
      write_q   <= 1'b0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= (phase == PH_DATA) && last;
      if (accept) begin
        phase   <= PH_ALO;
        len_m1  <= (phase_len == '0) ? '0 : phase_len - 1'b1;
        addr_q  <= req_addr;
        write_q <= req_write;
        wdata_q <= req_wdata;
      end else if (last) begin
        case (phase)
          PH_ALO:  phase <= PH_AHI;
          PH_AHI:  phase <= PH_DATA;
          default: phase <= PH_IDLE;
        endcase
        if (phase == PH_DATA && !write_q) rsp_data <= rom_ad_i;
      end
    end
  end

  // R2: a taken request starts an access next cycle
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  // R8: completion pulse is one cycle wide
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R8: completion only follows a data phase
  a_r8_done_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(phase) == PH_DATA && !busy));
endmodule

// File: rtl/bootrom_port_ctrl.sv
module bootrom_port_ctrl
  import brp_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic [LEN_W-1:0]  phase_len,
  output logic              busy,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data,
  output logic [BYTE_W-1:0] rom_ad_o,
  output logic              rom_ad_oe,
  input  logic [BYTE_W-1:0] rom_ad_i,
  output logic [1:0]        rom_aux,
  output logic              rom_sel_n
);
  phase_e            phase;
  logic              last;
  logic [LEN_W-1:0]  len_m1;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [BYTE_W-1:0] wdata_q;

  brp_sequencer #(.LEN_W(LEN_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .phase_len(phase_len),
    .rom_ad_i(rom_ad_i), .last(last), .phase(phase), .len_m1(len_m1),
    .addr_q(addr_q), .write_q(write_q), .wdata_q(wdata_q),
    .req_ready(req_ready), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  brp_timer #(.LEN_W(LEN_W)) i_tmr (
    .clk(clk), .rst_n(rst_n), .run(phase != PH_IDLE), .len_m1(len_m1),
    .last(last)
  );

  brp_pinmux i_mux (
    .clk(clk), .rst_n(rst_n), .phase(phase), .last(last), .addr(addr_q),
    .write(write_q), .wdata(wdata_q), .ad_o(rom_ad_o), .ad_oe(rom_ad_oe),
    .aux(rom_aux), .sel_n(rom_sel_n)
  );

  // R3: select and busy agree for the whole access
  a_r3_sel_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_sel_n) == busy);
endmodule

// File: tb/test_bootrom_port_ctrl.sv
module test_bootrom_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [17:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic [3:0]  phase_len = 4'd4;
  logic        busy, rsp_valid;
  logic [7:0]  rsp_data, rom_ad_o, rom_ad_i;
  logic        rom_ad_oe, rom_sel_n;
  logic [1:0]  rom_aux;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] last_rd = 8'h00;

  always #5 clk = ~clk;

  bootrom_port_ctrl i_bootrom_port_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .phase_len(phase_len), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rom_ad_o(rom_ad_o), .rom_ad_oe(rom_ad_oe),
    .rom_ad_i(rom_ad_i), .rom_aux(rom_aux), .rom_sel_n(rom_sel_n)
  );

  // addr[38:21] write[20] wdata[19:12] len[11:8] rom byte[7:0]
  localparam logic [38:0] VECS [6] = '{
    {18'h2A5C7, 1'b0, 8'h00, 4'd4,  8'h3C},
    {18'h1F0F3, 1'b1, 8'hA5, 4'd4,  8'h00},
    {18'h00001, 1'b0, 8'h00, 4'd1,  8'h81},
    {18'h3FFFE, 1'b1, 8'h5A, 4'd2,  8'h00},
    {18'h10002, 1'b0, 8'h00, 4'd0,  8'hE7},
    {18'h2C03D, 1'b0, 8'h00, 4'd15, 8'h96}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // idle pins: {sel_n, oe, aux, busy, ready, rsp_valid, ad_o}
  task automatic chk_idle(input string tag);
    chk(tag, {rom_sel_n, rom_ad_oe, rom_aux, busy, req_ready, rsp_valid, rom_ad_o},
        {1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 8'h00});
  endtask

  task automatic run_access(input logic [17:0] a, input logic w, input logic [7:0] wd,
                            input logic [3:0] ln, input logic [7:0] rd, input bit inject);
    int L;
    L = (ln == 0) ? 1 : int'(ln);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = wd; phase_len = ln;
    @(posedge clk);
    for (int i = 0; i < 3 * L; i++) begin
      int ph;
      bit lst;
      logic [7:0] e_ad;
      logic       e_oe;
      logic [1:0] e_aux;
      string tag;
      @(negedge clk);
      if (i == 0) begin req_valid = 1'b0; phase_len = 4'd7; end
      if (inject && i == 1) begin req_valid = 1'b1; req_addr = ~a; req_write = ~w; end
      if (inject && i == 3 * L - 1) req_valid = 1'b0;
      ph  = i / L;
      lst = ((i % L) == L - 1);
      rom_ad_i = (ph == 2 && lst) ? rd : ~rd;
      if (ph == 0) begin
        e_ad = {a[7:2], ~w, w}; e_oe = 1'b1; e_aux = {lst, a[16]}; tag = "R4/R6 addr-low";
      end else if (ph == 1) begin
        e_ad = a[15:8]; e_oe = 1'b1; e_aux = {lst, a[17]}; tag = "R5/R6 addr-high";
      end else begin
        e_ad = w ? wd : 8'h00; e_oe = w; e_aux = a[1:0]; tag = "R7 data";
      end
      chk(tag, {rom_ad_o, rom_ad_oe, rom_aux}, {e_ad, e_oe, e_aux});
      chk(inject ? "R2/R3 busy, request ignored" : "R3 busy/select",
          {rom_sel_n, busy, req_ready, rsp_valid}, {1'b0, 1'b1, 1'b0, 1'b0});
    end
    @(negedge clk);
    if (!w) last_rd = rd;
    chk(w ? "R9 write done" : "R8 read done",
        {rsp_valid, busy, rom_sel_n, rsp_data}, {1'b1, 1'b0, 1'b1, last_rd});
    @(negedge clk);
    chk("R8 done one cycle / R1 idle", {rsp_valid, rom_sel_n, busy, rsp_data},
        {1'b0, 1'b1, 1'b0, last_rd});
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    rom_ad_i = 8'h00;
    #1;
    chk_idle("R1 in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after reset");
    chk("R1 rsp_data reset", {24'h0, rsp_data}, 32'h0);

    for (int v = 0; v < 6; v++)
      run_access(VECS[v][38:21], VECS[v][20], VECS[v][19:12], VECS[v][11:8],
                 VECS[v][7:0], 1'b0);

    // R2: request held through an access is ignored until done
    run_access(18'h155AA, 1'b0, 8'h00, 4'd3, 8'h4D, 1'b1);
    repeat (3) begin
      @(negedge clk);
      chk_idle("R2 ignored request left no access");
    end

    // R3: back-to-back accesses, minimal length
    run_access(18'h3C3C3, 1'b1, 8'hC3, 4'd1, 8'h00, 1'b0);
    run_access(18'h0C3C0, 1'b0, 8'h00, 4'd1, 8'h18, 1'b0);
    // R9: write after read keeps the read byte
    run_access(18'h00000, 1'b1, 8'hFF, 4'd2, 8'h00, 1'b0);

    // R1: reset in mid-access returns to idle
    @(negedge clk);
    req_valid = 1'b1; req_addr = 18'h12345; req_write = 1'b0; phase_len = 4'd5;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_idle("R1 reset mid-access");
    chk("R1 rsp_data cleared", {24'h0, rsp_data}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 idle after reset release");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule